// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read-only direct-mapped cache paired with a small fully associative victim buffer. The buffer holds lines the main array recently displaced. A request first checks the main array. Only when that check misses does the block search the victim buffer, one cycle later, using the full line address. A hit in the buffer exchanges two lines: the hit line moves back into the main array, and the line it displaces takes the buffer slot. When both stores miss, the block sends a refill request to the next level. When the refill data arrives, it goes into the main array. The displaced main-array line enters the buffer, and the buffer entry that line overwrites is sent down on the eviction output.

Each line is one data word. An address is a tag above a set index. Buffer entries keep both fields, because an entry is not tied to any set. The buffer chooses the slot it overwrites in first-in, first-out order.

Top module: `victim_dm_cache`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid, refill_req_valid and evict_valid are 0. Every line in both stores is invalid, so the first access to any address is a double miss with no eviction.
- R2: A request accepted at a clock edge (req_valid and req_ready both 1) that hits in the main array gives resp_valid=1 for one cycle after that same edge, with the line's data and resp_src=2'b00. It causes no refill request and no eviction.
- R3: A request that misses in the main array but hits in the victim buffer gives resp_valid=1 with resp_src=2'b01 and the line's data two edges after acceptance. The hit line then sits in the main array, and the displaced main-array line sits in the hit line's former buffer slot.
- R4: On a miss in both stores, refill_req_valid pulses for exactly one cycle, two edges after acceptance, with refill_req_addr equal to the full request address. One edge after refill_valid is sampled, resp_valid=1 with resp_src=2'b10 and resp_data equal to refill_data.
- R5: On a double miss, a valid displaced main-array line is written into the victim buffer. An invalid one is not written, and in that case no eviction follows.
- R6: The victim buffer has 4 entries. An insertion overwrites the slot under a pointer that advances by one per insertion, wrapping around. A swap reuses the hit slot and leaves the pointer unchanged. If the overwritten slot held a valid line, evict_valid pulses in the same cycle as the refill response, carrying that line's address and data.
- R7: req_ready is 0 from the edge after a main-array miss is accepted until the miss completes. Requests made while it is 0 are ignored. refill_valid is ignored unless a refill is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request valid |
| req_addr | input | TAG_W+IDX_W | CPU line address, tag above index |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | Response valid, one cycle |
| resp_data | output | DATA_W | Response data |
| resp_src | output | 2 | 00 main array, 01 victim buffer, 10 refill |
| refill_req_valid | output | 1 | Refill request pulse to the next level |
| refill_req_addr | output | TAG_W+IDX_W | Address of the refill request |
| refill_valid | input | 1 | Refill data valid from the next level |
| refill_data | input | DATA_W | Refill data |
| evict_valid | output | 1 | Victim-buffer line pushed down, one cycle |
| evict_addr | output | TAG_W+IDX_W | Address of the pushed-down line |
| evict_data | output | DATA_W | Data of the pushed-down line |

## Verification
The bench aims at ping-pong patterns: two addresses that share one set, accessed in turn, so the same pair swaps repeatedly. A design that failed to return the displaced line to the freed slot would lose one of the pair and report a refill where a buffer hit is due.

The bench also fills the buffer past four insertions with swaps mixed in. This catches a pointer that moves on a swap or evicts the wrong slot, which shows up as a wrong evict_addr.

It drives junk requests and junk refill data while a miss is outstanding, and a refill pulse while the block is idle. A design that accepted either input would show a stray response or corrupted data on a later hit. Refill latency is varied so that the response timing and the one-cycle request pulse are checked at every gap.

// File: rtl/victim_dm_cache.sv
module victim_dm_cache #(
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8,
  parameter int VICT_N = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [TAG_W+IDX_W-1:0]  req_addr,
  output logic                    req_ready,
  output logic                    resp_valid,
  output logic [DATA_W-1:0]       resp_data,
  output logic [1:0]              resp_src,
  output logic                    refill_req_valid,
  output logic [TAG_W+IDX_W-1:0]  refill_req_addr,
  input  logic                    refill_valid,
  input  logic [DATA_W-1:0]       refill_data,
  output logic                    evict_valid,
  output logic [TAG_W+IDX_W-1:0]  evict_addr,
  output logic [DATA_W-1:0]       evict_data
);
  localparam int AW   = TAG_W + IDX_W;
  localparam int SETS = 1 << IDX_W;
  localparam int VP_W = (VICT_N > 1) ? $clog2(VICT_N) : 1;

  typedef enum logic [1:0] {S_IDLE, S_VLOOK, S_RWAIT} state_t;
  state_t state;

  logic [TAG_W-1:0]  dm_tag [SETS];
  logic [DATA_W-1:0] dm_dat [SETS];
  logic [SETS-1:0]   dm_v;
  logic [AW-1:0]     vc_addr [VICT_N];
  logic [DATA_W-1:0] vc_dat  [VICT_N];
  logic [VICT_N-1:0] vc_v;
  logic [VP_W-1:0]   vc_ptr;
  logic [AW-1:0]     a_q;

  wire [IDX_W-1:0] in_idx = req_addr[IDX_W-1:0];
  wire [TAG_W-1:0] in_tag = req_addr[AW-1:IDX_W];
  wire [IDX_W-1:0] a_idx  = a_q[IDX_W-1:0];
  wire [TAG_W-1:0] a_tag  = a_q[AW-1:IDX_W];
  wire [AW-1:0]    displaced = {dm_tag[a_idx], a_idx};

  assign req_ready       = (state == S_IDLE);
  assign refill_req_addr = a_q;

  wire accept = req_valid && req_ready;
  wire dm_hit = dm_v[in_idx] && (dm_tag[in_idx] == in_tag);

  logic            vc_hit;
  logic [VP_W-1:0] vc_sel;
  always_comb begin
    vc_hit = 1'b0;
    vc_sel = '0;
    for (int i = 0; i < VICT_N; i++)
      if (vc_v[i] && vc_addr[i] == a_q) begin
        vc_hit = 1'b1;
        vc_sel = VP_W'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state            <= S_IDLE;
      dm_v             <= '0;
      vc_v             <= '0;
      vc_ptr           <= '0;
      a_q              <= '0;
      resp_valid       <= 1'b0;
      resp_data        <= '0;
      resp_src         <= 2'b00;
      refill_req_valid <= 1'b0;
      evict_valid      <= 1'b0;
      evict_addr       <= '0;
      evict_data       <= '0;
    end else begin
      resp_valid       <= 1'b0;
      refill_req_valid <= 1'b0;
      evict_valid      <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          a_q <= req_addr;
          if (dm_hit) begin
            resp_valid <= 1'b1;
            resp_data  <= dm_dat[in_idx];
            resp_src   <= 2'b00;
          end else begin
            state <= S_VLOOK;
          end
        end
        S_VLOOK: begin
          if (vc_hit) begin
            dm_tag[a_idx]   <= a_tag;
            dm_dat[a_idx]   <= vc_dat[vc_sel];
            dm_v[a_idx]     <= 1'b1;
            vc_addr[vc_sel] <= displaced;
            vc_dat[vc_sel]  <= dm_dat[a_idx];
            vc_v[vc_sel]    <= dm_v[a_idx];
            resp_valid      <= 1'b1;
            resp_data       <= vc_dat[vc_sel];
            resp_src        <= 2'b01;
            state           <= S_IDLE;
          end else begin
            refill_req_valid <= 1'b1;
            state            <= S_RWAIT;
          end
        end
        S_RWAIT: if (refill_valid) begin
          dm_tag[a_idx] <= a_tag;
          dm_dat[a_idx] <= refill_data;
          dm_v[a_idx]   <= 1'b1;
          resp_valid    <= 1'b1;
          resp_data     <= refill_data;
          resp_src      <= 2'b10;
          if (dm_v[a_idx]) begin
            vc_addr[vc_ptr] <= displaced;
            vc_dat[vc_ptr]  <= dm_dat[a_idx];
            vc_v[vc_ptr]    <= 1'b1;
            vc_ptr          <= (vc_ptr == VP_W'(VICT_N - 1)) ? '0 : vc_ptr + 1'b1;
            evict_valid     <= vc_v[vc_ptr];
            evict_addr      <= vc_addr[vc_ptr];
            evict_data      <= vc_dat[vc_ptr];
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dm_hit |=> resp_valid && resp_src == 2'b00 && !refill_req_valid);

  a_r3_victim_hit_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_VLOOK) && vc_hit |=> resp_valid && resp_src == 2'b01);

  a_r4_refill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req_valid |=> !refill_req_valid);

  a_r4_refill_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RWAIT) && refill_valid |=> resp_valid && resp_src == 2'b10 && resp_data == $past(refill_data));

  a_r6_evict_with_refill: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> resp_valid && resp_src == 2'b10);

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req_valid |-> !req_ready);

endmodule

// File: tb/victim_dm_cache_bench.sv
`timescale 1ns/1ps
module victim_dm_cache_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [5:0] req_addr = '0;
  logic req_ready, resp_valid, refill_req_valid, evict_valid;
  logic [7:0] resp_data, evict_data;
  logic [1:0] resp_src;
  logic [5:0] refill_req_addr, evict_addr;
  logic refill_valid = 1'b0;
  logic [7:0] refill_data = '0;

  always #4 clk = ~clk;

  victim_dm_cache u_victim_dm_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_src(resp_src), .refill_req_valid(refill_req_valid),
    .refill_req_addr(refill_req_addr), .refill_valid(refill_valid),
    .refill_data(refill_data), .evict_valid(evict_valid),
    .evict_addr(evict_addr), .evict_data(evict_data));

  int total = 0;
  int fails = 0;

  int m_dv [4];
  int m_dt [4];
  int m_vv [4];
  int m_va [4];
  int m_ptr = 0;

  function automatic logic [7:0] mem(input logic [5:0] a);
    return ({2'b00, a} * 8'd7) + 8'h13;
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic access(input logic [5:0] a, input int dly, input bit noise);
    int idx, tag, kind, j;
    idx = int'(a[1:0]);
    tag = int'(a[5:2]);
    j = -1;
    if (m_dv[idx] != 0 && m_dt[idx] == tag) kind = 0;
    else begin
      for (int k = 0; k < 4; k++)
        if (m_vv[k] != 0 && m_va[k] == int'(a)) j = k;
      kind = (j >= 0) ? 1 : 2;
    end
    @(negedge clk);
    chk("R7 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = (kind != 0) && noise;
    req_addr  = a ^ 6'h2A;
    if (kind == 0) begin
      chk("R2 resp_valid", int'(resp_valid), 1);
      chk("R2 resp_src", int'(resp_src), 0);
      chk("R2 resp_data", int'(resp_data), int'(mem(a)));
      chk("R2 no refill", int'(refill_req_valid), 0);
      chk("R2 no evict", int'(evict_valid), 0);
      return;
    end
    chk("R3 no early resp", int'(resp_valid), 0);
    chk("R7 busy not ready", int'(req_ready), 0);
    if (noise) begin
      refill_valid = 1'b1;
      refill_data  = 8'hEE;
    end
    @(negedge clk);
    refill_valid = 1'b0;
    if (kind == 1) begin
      req_valid = 1'b0;
      chk("R3 resp_valid", int'(resp_valid), 1);
      chk("R3 resp_src", int'(resp_src), 1);
      chk("R3 resp_data", int'(resp_data), int'(mem(a)));
      chk("R3 no refill", int'(refill_req_valid), 0);
      chk("R3 no evict", int'(evict_valid), 0);
      m_va[j]  = m_dt[idx] * 4 + idx;
      m_dt[idx] = tag;
      return;
    end
    chk("R4 refill_req_valid", int'(refill_req_valid), 1);
    chk("R4 refill_req_addr", int'(refill_req_addr), int'(a));
    chk("R4 no early resp", int'(resp_valid), 0);
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      chk("R4 refill pulse once", int'(refill_req_valid), 0);
      chk("R4 wait no resp", int'(resp_valid), 0);
      chk("R7 wait not ready", int'(req_ready), 0);
    end
    refill_valid = 1'b1;
    refill_data  = mem(a);
    req_valid    = 1'b0;
    @(negedge clk);
    refill_valid = 1'b0;
    chk("R4 resp_valid", int'(resp_valid), 1);
    chk("R4 resp_src", int'(resp_src), 2);
    chk("R4 resp_data", int'(resp_data), int'(mem(a)));
    if (m_dv[idx] != 0) begin
      chk("R6 evict_valid", int'(evict_valid), m_vv[m_ptr]);
      if (m_vv[m_ptr] != 0) begin
        chk("R6 evict_addr", int'(evict_addr), m_va[m_ptr]);
        chk("R6 evict_data", int'(evict_data), int'(mem(6'(m_va[m_ptr]))));
      end
      m_va[m_ptr] = m_dt[idx] * 4 + idx;
      m_vv[m_ptr] = 1;
      m_ptr = (m_ptr + 1) % 4;
    end else begin
      chk("R5 invalid line not inserted", int'(evict_valid), 0);
    end
    m_dv[idx] = 1;
    m_dt[idx] = tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int k = 0; k < 4; k++) begin
      m_dv[k] = 0; m_dt[k] = 0; m_vv[k] = 0; m_va[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 ready after reset", int'(req_ready), 1);
    chk("R1 resp_valid after reset", int'(resp_valid), 0);
    chk("R1 refill after reset", int'(refill_req_valid), 0);
    chk("R1 evict after reset", int'(evict_valid), 0);

    access(6'h05, 0, 1'b0);
    access(6'h05, 0, 1'b0);
    access(6'h15, 2, 1'b1);
    access(6'h05, 0, 1'b0);
    access(6'h15, 0, 1'b1);
    access(6'h15, 0, 1'b0);
    access(6'h25, 1, 1'b0);
    access(6'h35, 3, 1'b1);
    access(6'h45, 0, 1'b0);
    access(6'h55, 1, 1'b0);
    access(6'h65, 0, 1'b1);
    access(6'h25, 0, 1'b0);

    @(negedge clk);
    refill_valid = 1'b1;
    refill_data  = 8'h99;
    @(negedge clk);
    refill_valid = 1'b0;
    chk("R7 idle refill no resp", int'(resp_valid), 0);
    chk("R7 idle refill no evict", int'(evict_valid), 0);
    access(6'h25, 0, 1'b0);

    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      access({lf[11:10], lf[3:0]}, int'(lf[7:6]), lf[8]);
    end
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule